// File: doc/BRIEF.md
# Write-Synchronized Control Register

This block is an 8-bit control register. Software reads and writes it over a simple bus port in a fast bus clock domain. It drives a peripheral core that runs on a separate, slower clock. Two of the fields set static analog options, a low-power input selection and run-during-standby. These fields act on their outputs as soon as they are written. The other two fields, enable and software reset, must be applied by the core domain, so they cross the clock boundary through a toggle request and acknowledge handshake.

While a crossing is in flight, a busy flag is raised and the register holds its enable and reset fields. Readback of the enable field shows the written value at once, before the core has acted on it. A software-reset write wins over every other field in the same write. It clears the register, holds the register read-only until the core has seen the reset, and then clears itself together with the busy flag. The core side receives a one-cycle reset pulse and a held enable level.

Top module: `wsync_ctrl_reg`

## Requirements
- R1: Field positions are fixed: bit 7 is the low-power select, bit 2 is run-in-standby, bit 1 is enable and bit 0 is software reset. Bits 6 down to 3 always read 0.
- R2: After reset the read value is 0x00, and sync_busy, lp_mux_sel, run_standby, core_enable and core_soft_rst are all 0.
- R3: A write with bit 0 set, made while sync_busy is 0, discards every other bit of that write. On the next bus cycle the register reads 0x01, sync_busy is 1, and lp_mux_sel and run_standby are 0.
- R4: A write with bit 0 clear starts no reset. It updates the other fields like any normal write.
- R5: A write made while sync_busy is 0, with bit 0 clear and a bit 1 that differs from the stored enable, raises sync_busy on the next bus cycle. From that cycle, bit 1 of the read value shows the new enable. A write that leaves the enable unchanged raises no busy.
- R6: core_enable takes the new enable only after the request has crossed into the core clock, and never in the bus cycle after the write. A completed software reset gives exactly one core-cycle pulse on core_soft_rst, with core_enable at 0.
- R7: sync_busy stays high until the core acknowledge has returned. core_enable already holds the requested value when sync_busy falls. During a reset, bit 0 reads 1 and clears in the same cycle as sync_busy.
- R8: While sync_busy is 1, bits 1 and 0 of a write are ignored. Bits 7 and 2 are still accepted, except during a software reset.
- R9: Bits 7 and 2 of an accepted write appear on lp_mux_sel and run_standby on the next bus cycle, and they never raise sync_busy.
- R10: While a software reset is in progress, every write is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| sync_busy | output | 1 | A crossing into the core domain is in flight |
| lp_mux_sel | output | 1 | Low-power input selection, applied directly |
| run_standby | output | 1 | Keep running in standby, applied directly |
| core_clk | input | 1 | Core clock |
| core_rst_n | input | 1 | Asynchronous active-low reset, core domain |
| core_enable | output | 1 | Enable level in the core domain |
| core_soft_rst | output | 1 | One-cycle reset pulse in the core domain |

## Verification
The bench aims at four cases:
- A write that sets reset and enable together. A design that let the enable through would show 0x03 or leave the core enabled.
- Writes made while busy. A design that accepted them would change the enable mid-crossing, so the core would apply a value that software never saw settle.
- Writes during a reset, which must leave the register at 0x01.
- The exact cycle in which sync_busy and the reset bit fall. A design that cleared them one cycle apart, or before the core had acted, shows a busy low with core_enable still stale.

Random writes with random idle gaps sweep accept/ignore decisions against the moment busy drops.

// File: rtl/wsync_ctrl_reg.sv
module wsync_ctrl_reg (
  input  logic       bus_clk,
  input  logic       bus_rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       sync_busy,
  output logic       lp_mux_sel,
  output logic       run_standby,
  input  logic       core_clk,
  input  logic       core_rst_n,
  output logic       core_enable,
  output logic       core_soft_rst
);
  localparam int BitSrst = 0;
  localparam int BitEn   = 1;
  localparam int BitStby = 2;
  localparam int BitMux  = 7;

  logic mux_q, stby_q, en_q, srst_q, req_tgl, ack_s1, ack_s2;
  logic req_s1, req_s2, req_s3, core_en_q, core_srst_q;

  assign sync_busy = req_tgl ^ ack_s2;

  wire srst_wr = wr_en && !sync_busy && wr_data[BitSrst];
  wire en_wr   = wr_en && !sync_busy && !wr_data[BitSrst] && (wr_data[BitEn] != en_q);
  wire dir_wr  = wr_en && !srst_q && !srst_wr;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      {mux_q, stby_q, en_q, srst_q, req_tgl, ack_s1, ack_s2} <= '0;
    end else begin
      ack_s1 <= req_s3;
      ack_s2 <= ack_s1;
      if (srst_wr) begin
        srst_q  <= 1'b1;
        en_q    <= 1'b0;
        mux_q   <= 1'b0;
        stby_q  <= 1'b0;
        req_tgl <= ~req_tgl;
      end else begin
        if (en_wr) begin
          en_q    <= wr_data[BitEn];
          req_tgl <= ~req_tgl;
        end
        if (dir_wr) begin
          mux_q  <= wr_data[BitMux];
          stby_q <= wr_data[BitStby];
        end
        if (srst_q && (ack_s1 == req_tgl)) srst_q <= 1'b0;
      end
    end
  end

  assign rd_data     = {mux_q, 4'b0000, stby_q, en_q, srst_q};
  assign lp_mux_sel  = mux_q;
  assign run_standby = stby_q;

  wire req_new = req_s2 ^ req_s3;

  always_ff @(posedge core_clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      {req_s1, req_s2, req_s3, core_en_q, core_srst_q} <= '0;
    end else begin
      req_s1      <= req_tgl;
      req_s2      <= req_s1;
      req_s3      <= req_s2;
      core_srst_q <= req_new && srst_q;
      if (req_new) core_en_q <= en_q && !srst_q;
    end
  end

  assign core_enable   = core_en_q;
  assign core_soft_rst = core_srst_q;
endmodule

// File: rtl/wsync_ctrl_reg_chk.sv
module wsync_ctrl_reg_chk (
  input logic       bus_clk,
  input logic       bus_rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sync_busy,
  input logic       lp_mux_sel,
  input logic       run_standby,
  input logic       core_clk,
  input logic       core_rst_n,
  input logic       core_enable,
  input logic       core_soft_rst
);
  AST_UNUSED_ZERO: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    rd_data[6:3] == 4'b0000); // R1

  AST_SRST_WINS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    wr_en && !sync_busy && wr_data[0] |=> (rd_data == 8'h01) && sync_busy); // R3

  AST_EN_HANDSHAKE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    wr_en && !sync_busy && !wr_data[0] && (wr_data[1] != rd_data[1])
    |=> sync_busy && (rd_data[1] == $past(wr_data[1]))); // R5

  AST_SRST_HOLDS_BUSY: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    rd_data[0] |-> sync_busy); // R7

  AST_EN_FROZEN_BUSY: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    sync_busy |=> $stable(rd_data[1])); // R8

  AST_DIRECT_APPLY: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    wr_en && !rd_data[0] && !(wr_data[0] && !sync_busy)
    |=> (lp_mux_sel == $past(wr_data[7])) && (run_standby == $past(wr_data[2]))); // R9

  AST_CORE_SRST_OFF: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    core_soft_rst |-> !core_enable); // R6

  AST_CORE_SRST_PULSE: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    core_soft_rst |=> !core_soft_rst); // R6
endmodule

bind wsync_ctrl_reg wsync_ctrl_reg_chk u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .sync_busy(sync_busy), .lp_mux_sel(lp_mux_sel),
  .run_standby(run_standby), .core_clk(core_clk), .core_rst_n(core_rst_n),
  .core_enable(core_enable), .core_soft_rst(core_soft_rst)
);

// File: tb/wsync_ctrl_reg_test.sv
`timescale 1ns/1ps
module wsync_ctrl_reg_test;
  logic bus_clk = 0, core_clk = 0, bus_rst_n = 0, core_rst_n = 0;
  logic wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic sync_busy, lp_mux_sel, run_standby, core_enable, core_soft_rst;

  always #2 bus_clk = ~bus_clk;
  always #6.85 core_clk = ~core_clk;

  wsync_ctrl_reg uut (.*);

  int checks = 0, fails = 0, pulses = 0, exp_pulses = 0;
  logic m_mux = 0, m_stby = 0, m_en = 0, m_srst = 0;

  always @(posedge core_clk) if (core_soft_rst) pulses++;

  function automatic logic [7:0] exp_rd();
    return {m_mux, 4'b0000, m_stby, m_en, m_srst};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle of idle, tracking busy fall; returns at negedge
  task automatic tick();
    logic was_busy;
    was_busy = sync_busy;
    @(negedge bus_clk);
    if (was_busy && !sync_busy) begin
      if (m_srst) begin m_srst = 0; exp_pulses++; end
      check("R7 enable applied at busy fall", {7'd0, core_enable}, {7'd0, m_en});
      check("R7 reset bit clears with busy", rd_data, exp_rd());
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (sync_busy && n < 100) begin tick(); n++; end
    check("R7 busy eventually clears", {7'd0, sync_busy}, 8'd0);
  endtask

  task automatic do_write(input logic [7:0] d);
    logic busy_before, core_before, started;
    busy_before = sync_busy;
    core_before = core_enable;
    started = 0;
    if (m_srst) begin
    end else if (!busy_before && d[0]) begin
      m_srst = 1; m_en = 0; m_mux = 0; m_stby = 0; started = 1;
    end else begin
      if (!busy_before && d[1] != m_en) begin m_en = d[1]; started = 1; end
      m_mux = d[7]; m_stby = d[2];
    end
    wr_en = 1; wr_data = d;
    @(negedge bus_clk);
    wr_en = 0;
    if (busy_before && !sync_busy && m_srst) begin m_srst = 0; exp_pulses++; end
    check("R3/R8/R10 readback", rd_data, exp_rd());
    check("R9 direct outputs", {6'd0, lp_mux_sel, run_standby}, {6'd0, m_mux, m_stby});
    if (started) begin
      check("R5 busy raised", {7'd0, sync_busy}, 8'd1);
      check("R6 core enable not yet changed", {7'd0, core_enable}, {7'd0, core_before});
    end else if (!busy_before) begin
      check("R5/R9 no handshake", {7'd0, sync_busy}, 8'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge bus_clk);
    fails++;
    $display("FAIL watchdog actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge bus_clk);
    bus_rst_n = 1; core_rst_n = 1;
    @(negedge bus_clk);
    check("R2 reset value", rd_data, 8'h00);
    check("R2 reset outputs", {3'd0, sync_busy, lp_mux_sel, run_standby, core_enable, core_soft_rst}, 8'd0);

    do_write(8'h02);
    tick();
    check("R7 busy held during crossing", {7'd0, sync_busy}, 8'd1);
    check("R6 core enable still old", {7'd0, core_enable}, 8'd0);
    wait_idle();
    check("R6 core enabled", {7'd0, core_enable}, 8'd1);

    do_write(8'h86);
    check("R1 layout", rd_data, 8'h86);

    do_write(8'h00);
    do_write(8'h87);
    check("R8 busy write keeps direct bits only", rd_data, 8'h84);
    wait_idle();
    check("R8 core disabled", {7'd0, core_enable}, 8'd0);

    do_write(8'h02);
    wait_idle();
    do_write(8'h83);
    check("R3 reset wins", rd_data, 8'h01);
    check("R3 direct outputs cleared", {6'd0, lp_mux_sel, run_standby}, 8'd0);
    do_write(8'h84);
    check("R10 write during reset ignored", rd_data, 8'h01);
    wait_idle();
    check("R7 reset done", rd_data, 8'h00);
    repeat (4) @(negedge core_clk);
    @(negedge bus_clk);
    check("R6 one core reset pulse", pulses[7:0], exp_pulses[7:0]);
    check("R6 core off after reset", {7'd0, core_enable}, 8'd0);

    do_write(8'h80);
    check("R4 bit0 clear is a normal write", rd_data, 8'h80);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (($urandom % 4) != 0) d[0] = 1'b0;
      do_write(d);
      repeat ($urandom % 7) tick();
    end
    wait_idle();
    repeat (4) @(negedge core_clk);
    @(negedge bus_clk);
    check("R6 final core enable", {7'd0, core_enable}, {7'd0, m_en});
    check("R6 pulse count", pulses[7:0], exp_pulses[7:0]);
    check("R1 final readback", rd_data, exp_rd());

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule